// File: doc/BRIEF.md
# Timer Interrupt Vector Generator

This block gathers the interrupt flags of a timer that has one dedicated capture/compare channel (channel 0) and a set of shared channels (1 to NUM_SHARED). Channel 0 has a flag and a request line of its own. That flag clears in hardware when the interrupt controller acknowledges the request. The shared channels latch their flags from per-channel set events, and their enabled flags are ORed into a second request line.

Software finds out which shared channel fired by accessing a 16-bit vector register. The register shows one code, for the highest-priority enabled pending channel. A read of the register, or an attempted write to it, clears that one flag and no other, so a handler can service the sources one access at a time. A flag can also be cleared directly through a mask write, which mirrors writing zero to the flag bit in the channel's control register.

All pins are plain control and status signals. No data stream crosses the block's edge, so it has no valid/ready handshake and applies no back-pressure: a set event, an acknowledge or an access takes effect at the next rising clock edge.

Top module: `tivg_top`

## Requirements
- R1: After reset every flag is 0, both request outputs are low and the vector reads 0.
- R2: A pulse on `ch0_set_i` sets the channel 0 flag at the next edge. `ch0_irq_o` is the flag ANDed with `ch0_en_i`. A pulse on `ch0_ack_i` clears the flag at the next edge.
- R3: `sh_irq_o` is high exactly while at least one shared flag is both set and enabled. It stays high until those flags are cleared.
- R4: The vector is 16 bits wide. Bits 15..4 and bit 0 are always 0. Shared channel n (flag index n-1) reports the code 2*n, and the code 0 means that nothing is pending.
- R5: When several enabled flags are pending, the vector shows the lowest-numbered channel.
- R6: At the edge that ends a cycle with `vec_rd_i` or `vec_wr_i` high, only the flag whose code was being shown is cleared. The other shared flags are untouched.
- R7: When `sh_clr_we_i` is high, every shared flag whose bit is 1 in `sh_clr_mask_i` is cleared at the next edge.
- R8: A shared flag whose enable is 0 still latches, and it can be seen on `sh_flag_o`. It does not drive `sh_irq_o`, it does not appear in the vector, and a vector access does not clear it.
- R9: If a set event and any clear (acknowledge, vector access or mask write) hit the same flag in the same cycle, the flag is 1 after the edge.
- R10: In a cycle with a vector access, `vec_o` shows the code as it was before the clear. The next code appears after the edge.
- R11: Channel 0 never appears in the vector, and a vector access does not change the channel 0 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch0_set_i | input | 1 | Channel 0 capture/compare event |
| ch0_en_i | input | 1 | Channel 0 interrupt enable |
| ch0_ack_i | input | 1 | Acknowledge of the channel 0 request |
| sh_set_i | input | NUM_SHARED | Set events of the shared channels (bit k is channel k+1) |
| sh_en_i | input | NUM_SHARED | Interrupt enables of the shared channels |
| sh_clr_we_i | input | 1 | Strobe for a direct flag-clear write |
| sh_clr_mask_i | input | NUM_SHARED | Flags to clear when the strobe is high (1 = clear) |
| vec_rd_i | input | 1 | Read strobe for the vector register |
| vec_wr_i | input | 1 | Write strobe for the vector register (data is ignored) |
| vec_o | output | 16 | Vector register read data |
| ch0_flag_o | output | 1 | Channel 0 flag |
| sh_flag_o | output | NUM_SHARED | Shared channel flags, as the control registers read them |
| ch0_irq_o | output | 1 | Dedicated request line for channel 0 |
| sh_irq_o | output | 1 | Merged request line for the shared channels |

## Verification
The bench builds the block with NUM_SHARED = 6, which matches a timer with seven capture/compare channels in total. With that value every shared code from 2 to 12 can be produced, and a six-step drain by successive reads checks the whole priority order. Because the bench keeps the full set of channels, it can hold a disabled low-numbered flag alongside an enabled higher one. That lets it show that the access clears the channel being shown, not the lowest pending bit.

// File: rtl/tivg_pkg.sv
package tivg_pkg;
  localparam int VEC_W  = 16;
  localparam int CODE_W = 4;
  localparam int MAX_SHARED = 7;

  // Code for shared flag index idx (channel idx+1): twice the channel number.
  function automatic logic [CODE_W-1:0] chan_code(input int idx);
    return CODE_W'((idx + 1) * 2);
  endfunction
endpackage

// File: rtl/tivg_flag_bank.sv
module tivg_flag_bank #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_i,
  input  logic [WIDTH-1:0] clr_i,
  output logic [WIDTH-1:0] flag_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_o[g] <= 1'b0;
      else if (set_i[g])    flag_o[g] <= 1'b1;   // set beats clear
      else if (clr_i[g])    flag_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/tivg_prio_enc.sv
module tivg_prio_enc
  import tivg_pkg::*;
#(
  parameter int WIDTH = 6
) (
  input  logic [WIDTH-1:0]  req_i,
  output logic [CODE_W-1:0] code_o,
  output logic [WIDTH-1:0]  sel_o
);
  always_comb begin
    code_o = '0;
    sel_o  = '0;
    // Walk downwards so the lowest index is the one that remains.
    for (int i = WIDTH - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        code_o   = chan_code(i);
        sel_o    = '0;
        sel_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tivg_top.sv
module tivg_top
  import tivg_pkg::*;
#(
  parameter int NUM_SHARED = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ch0_set_i,
  input  logic                  ch0_en_i,
  input  logic                  ch0_ack_i,
  input  logic [NUM_SHARED-1:0] sh_set_i,
  input  logic [NUM_SHARED-1:0] sh_en_i,
  input  logic                  sh_clr_we_i,
  input  logic [NUM_SHARED-1:0] sh_clr_mask_i,
  input  logic                  vec_rd_i,
  input  logic                  vec_wr_i,
  output logic [VEC_W-1:0]      vec_o,
  output logic                  ch0_flag_o,
  output logic [NUM_SHARED-1:0] sh_flag_o,
  output logic                  ch0_irq_o,
  output logic                  sh_irq_o
);
  localparam int PAD_W = VEC_W - CODE_W;

  if (NUM_SHARED < 1 || NUM_SHARED > MAX_SHARED) begin : g_bad_param
    $error("NUM_SHARED must lie in 1..7 to fit the code field");
  end

  logic [NUM_SHARED-1:0] sh_live;
  logic [NUM_SHARED-1:0] sh_sel;
  logic [NUM_SHARED-1:0] sh_clr;
  logic [CODE_W-1:0]     code;
  logic                  vec_access;

  // Dedicated channel: acknowledge auto-clears.
  tivg_flag_bank #(.WIDTH(1)) u_ch0_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ch0_set_i),
    .clr_i  (ch0_ack_i),
    .flag_o (ch0_flag_o)
  );

  assign ch0_irq_o = ch0_flag_o & ch0_en_i;

  // Shared channels.
  assign sh_live    = sh_flag_o & sh_en_i;
  assign vec_access = vec_rd_i | vec_wr_i;

  tivg_prio_enc #(.WIDTH(NUM_SHARED)) u_prio (
    .req_i  (sh_live),
    .code_o (code),
    .sel_o  (sh_sel)
  );

  always_comb begin
    sh_clr = '0;
    if (vec_access)  sh_clr = sh_clr | sh_sel;
    if (sh_clr_we_i) sh_clr = sh_clr | sh_clr_mask_i;
  end

  tivg_flag_bank #(.WIDTH(NUM_SHARED)) u_sh_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sh_set_i),
    .clr_i  (sh_clr),
    .flag_o (sh_flag_o)
  );

  assign sh_irq_o = |sh_live;
  assign vec_o    = {{PAD_W{1'b0}}, code};
endmodule

// File: rtl/tivg_checker.sv
module tivg_checker #(
  parameter int NUM_SHARED = 6
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ch0_set_i,
  input logic                  ch0_ack_i,
  input logic [NUM_SHARED-1:0] sh_set_i,
  input logic                  sh_clr_we_i,
  input logic                  vec_rd_i,
  input logic                  vec_wr_i,
  input logic [15:0]           vec_o,
  input logic                  ch0_flag_o,
  input logic [NUM_SHARED-1:0] sh_flag_o,
  input logic                  sh_irq_o
);
  // R4: fixed zero bits of the vector
  a_r4_format: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o[15:4] == '0) && (vec_o[0] == 1'b0));

  // R3: merged request agrees with the vector encoder
  a_r3_irq_vs_code: assert property (@(posedge clk) disable iff (!rst_n)
    sh_irq_o == (vec_o != '0));

  // R2: acknowledge without a new event lowers the channel 0 flag
  a_r2_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ch0_ack_i && !ch0_set_i) |=> !ch0_flag_o);

  // R9: a set event always leaves the channel 0 flag high
  a_r9_ch0_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ch0_set_i |=> ch0_flag_o);

  // R9: shared set events always land
  a_r9_sh_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_set_i != '0) |=> ((sh_flag_o & $past(sh_set_i)) == $past(sh_set_i)));

  // R6: an access with a pending code removes exactly one flag
  a_r6_one_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_rd_i || vec_wr_i) && vec_o != '0 && sh_set_i == '0 && !sh_clr_we_i)
    |=> ($countones(sh_flag_o) + 1 == $countones($past(sh_flag_o))));

  // R11: a vector access leaves channel 0 alone
  a_r11_ch0_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((vec_rd_i || vec_wr_i) && !ch0_ack_i && !ch0_set_i) |=> $stable(ch0_flag_o));
endmodule

bind tivg_top tivg_checker #(.NUM_SHARED(NUM_SHARED)) u_tivg_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .ch0_set_i   (ch0_set_i),
  .ch0_ack_i   (ch0_ack_i),
  .sh_set_i    (sh_set_i),
  .sh_clr_we_i (sh_clr_we_i),
  .vec_rd_i    (vec_rd_i),
  .vec_wr_i    (vec_wr_i),
  .vec_o       (vec_o),
  .ch0_flag_o  (ch0_flag_o),
  .sh_flag_o   (sh_flag_o),
  .sh_irq_o    (sh_irq_o)
);

// File: tb/tivg_top_bench.sv
`timescale 1ns/1ps
module tivg_top_bench;
  localparam int N = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ch0_set_i = 0, ch0_en_i = 0, ch0_ack_i = 0;
  logic [N-1:0]  sh_set_i = '0, sh_en_i = '0, sh_clr_mask_i = '0;
  logic          sh_clr_we_i = 0, vec_rd_i = 0, vec_wr_i = 0;
  logic [15:0]   vec_o;
  logic          ch0_flag_o, ch0_irq_o, sh_irq_o;
  logic [N-1:0]  sh_flag_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  tivg_top #(.NUM_SHARED(N)) u_tivg_top (
    .clk(clk), .rst_n(rst_n),
    .ch0_set_i(ch0_set_i), .ch0_en_i(ch0_en_i), .ch0_ack_i(ch0_ack_i),
    .sh_set_i(sh_set_i), .sh_en_i(sh_en_i),
    .sh_clr_we_i(sh_clr_we_i), .sh_clr_mask_i(sh_clr_mask_i),
    .vec_rd_i(vec_rd_i), .vec_wr_i(vec_wr_i),
    .vec_o(vec_o), .ch0_flag_o(ch0_flag_o), .sh_flag_o(sh_flag_o),
    .ch0_irq_o(ch0_irq_o), .sh_irq_o(sh_irq_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One edge: inputs were driven at a falling edge, results read at the next.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    ch0_set_i = 0; ch0_ack_i = 0; sh_set_i = '0;
    sh_clr_we_i = 0; sh_clr_mask_i = '0; vec_rd_i = 0; vec_wr_i = 0;
  endtask

  task automatic t_reset();
    check(vec_o == 16'd0, "R1 vector", vec_o, 0);
    check(!ch0_irq_o && !sh_irq_o, "R1 requests", {ch0_irq_o, sh_irq_o}, 0);
    check(sh_flag_o == '0 && !ch0_flag_o, "R1 flags", sh_flag_o, 0);
  endtask

  task automatic t_ch0();
    ch0_en_i = 1; ch0_set_i = 1; tick();
    check(ch0_irq_o == 1, "R2 ch0 request", ch0_irq_o, 1);
    check(vec_o == 16'd0, "R11 ch0 not in vector", vec_o, 0);
    vec_rd_i = 1; tick();
    check(ch0_flag_o == 1, "R11 access keeps ch0", ch0_flag_o, 1);
    ch0_ack_i = 1; ch0_set_i = 1; tick();
    check(ch0_flag_o == 1, "R9 ch0 set beats ack", ch0_flag_o, 1);
    ch0_ack_i = 1; tick();
    check(ch0_flag_o == 0 && ch0_irq_o == 0, "R2 ack clears", ch0_flag_o, 0);
    ch0_en_i = 0;
  endtask

  task automatic t_priority();
    sh_en_i = '1;
    sh_set_i = 6'b010100; tick();              // channels 3 and 5
    check(vec_o == 16'd6, "R5 lowest channel shown", vec_o, 6);
    check(sh_irq_o == 1, "R3 merged request", sh_irq_o, 1);
    vec_rd_i = 1;
    #1 check(vec_o == 16'd6, "R10 pre-clear code", vec_o, 6);
    tick();
    check(sh_flag_o == 6'b010000, "R6 only shown flag cleared", sh_flag_o, 6'b010000);
    check(vec_o == 16'd10, "R4 code for channel 5", vec_o, 10);
    check(sh_irq_o == 1, "R3 request held", sh_irq_o, 1);
    vec_wr_i = 1; tick();
    check(sh_flag_o == '0 && vec_o == 0, "R6 write access clears", sh_flag_o, 0);
    check(sh_irq_o == 0, "R3 request drops", sh_irq_o, 0);
  endtask

  task automatic t_enable();
    sh_en_i = 6'b111110;
    sh_set_i = 6'b001001; tick();              // channels 1 (disabled) and 4
    check(vec_o == 16'd8, "R8 disabled channel hidden", vec_o, 8);
    vec_rd_i = 1; tick();
    check(sh_flag_o == 6'b000001, "R8 access skips disabled", sh_flag_o, 1);
    check(sh_irq_o == 0, "R8 no request when disabled", sh_irq_o, 0);
    sh_en_i = '1; #1;
    check(vec_o == 16'd2 && sh_irq_o, "R4 code for channel 1", vec_o, 2);
    sh_clr_we_i = 1; sh_clr_mask_i = 6'b000001; tick();
    check(sh_flag_o == '0 && vec_o == 0, "R7 direct clear", sh_flag_o, 0);
  endtask

  task automatic t_setwins();
    sh_set_i = 6'b000010; tick();
    vec_rd_i = 1; sh_set_i = 6'b000010; tick();
    check(sh_flag_o == 6'b000010 && vec_o == 4, "R9 set beats access", vec_o, 4);
    sh_clr_we_i = 1; sh_clr_mask_i = 6'b000010; sh_set_i = 6'b000010; tick();
    check(sh_flag_o == 6'b000010, "R9 set beats direct clear", sh_flag_o, 2);
    sh_clr_we_i = 1; sh_clr_mask_i = '1; tick();
    check(sh_flag_o == '0, "R7 mask clears all", sh_flag_o, 0);
  endtask

  task automatic t_drain();
    sh_set_i = '1; tick();
    for (int k = 1; k <= N; k++) begin
      check(vec_o == 16'(2 * k), "R5 drain order", vec_o, 2 * k);
      vec_rd_i = 1; tick();
    end
    check(vec_o == 16'd0 && !sh_irq_o, "R4 empty code", vec_o, 0);
  endtask

  initial begin
    #1000000;
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_ch0();
    t_priority();
    t_enable();
    t_setwins();
    t_drain();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule